// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the type-0 configuration header of a single-function multimedia video target on a PCI bus. The bus interface logic has already recognised a configuration cycle aimed at this function. It presents that cycle as a one-cycle access strobe carrying:

- a doubleword index,
- a read/write flag,
- four byte enables,
- write data.

The block answers reads with a registered data word one clock later. It applies writes lane by lane.

The header carries fixed identification and class fields and two writable command bits (bus mastering and memory-space decoding). It also holds:

- four sticky error flags, raised by one-cycle event pulses from the bus interface and cleared by software writing ones;
- a master latency timer whose three least significant bits are fixed at zero;
- one memory base address register that describes an aligned 4 KB window.

Every doubleword index that is not implemented reads as zero. The block compares incoming memory transaction addresses against the base register and produces a registered hit flag. The flag is qualified by the memory-space enable bit.

Top module: `cfg_space_hdr`

## Requirements
- R1: After synchronous reset, the command bits, the sticky status flags, the latency timer and the base address register all hold zero. `cfg_rdata`, `cfg_rvalid`, `mem_hit`, `bus_master_en`, `mem_space_en` and `lat_timer` all read 0.
- R2: Doubleword 0 reads `0x605711DE`, with the device identifier in bits 31:16 and the vendor identifier in bits 15:0. Writes to it change nothing.
- R3: Doubleword 2 reads `0x04000001`, with the class code in bits 31:8 and the revision in bits 7:0.
- R4: Every doubleword index from 5 to 63 reads zero, whatever has been written to it.
- R5: In doubleword 1, bit 1 (memory-space enable) and bit 2 (bus-master enable) are writable through byte lane 0. Every other bit of the low half reads 0. The two bits appear on `mem_space_en` and `bus_master_en`.
- R6: The hardwired status fields read zero: bit 30, the select-timing field in bits 26:25, bit 24, bit 23 and bits 22:16 of doubleword 1.
- R7: An event pulse sets its sticky flag in doubleword 1 at the next clock edge, regardless of the command bits. The mapping is: parity error to bit 31, master abort seen to bit 29, target abort received to bit 28, and target abort signalled to bit 27.
- R8: A write to doubleword 1 with byte lane 3 enabled clears each sticky flag whose data bit is 1. A data bit of 0, or lane 3 disabled, leaves the flag unchanged. An event in the same cycle as a clear of its flag leaves the flag set.
- R9: The latency timer occupies bits 15:8 of doubleword 3 and is written only through byte lane 1. Its bits 10:8 always read 0. All other bits of doubleword 3 read 0.
- R10: The base address register occupies doubleword 4. Bits 31:12 are writable, each byte lane only when its enable is set. Bits 11:0 read 0.
- R11: `mem_hit` is a register. One cycle after `mem_addr` is presented, it equals (memory-space enable) AND (`mem_addr[31:12]` == base bits 31:12).
- R12: A read strobe yields `cfg_rvalid` high with the read word on `cfg_rdata` in the following cycle. `cfg_rvalid` is low in the cycle after any other strobe or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Configuration access strobe, one cycle per access |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_dw | input | 6 | Doubleword index into the configuration space |
| cfg_be | input | 4 | Byte enables, bit i for data bits 8i+7:8i |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| ev_parity | input | 1 | Parity error detected pulse |
| ev_mabort | input | 1 | Master abort detected pulse |
| ev_tabort_rcv | input | 1 | Target abort received pulse |
| ev_tabort_sig | input | 1 | Target abort signalled pulse |
| mem_addr | input | 32 | Address of an incoming memory transaction |
| mem_hit | output | 1 | Registered window hit |
| mem_space_en | output | 1 | Memory-space enable command bit |
| bus_master_en | output | 1 | Bus-master enable command bit |
| lat_timer | output | 8 | Master latency timer value |

## Verification
The bench builds the block with its default parameters: a 256-byte space (64 doublewords), a 12-bit window offset and 3 fixed latency bits. With these values, the last doubleword index, index 63, is reachable from the bench. The window-edge addresses 0x...000 and 0x...FFF, and the first address of the next page, can all be tested against the 4 KB boundary. The latency-timer check can observe the three constant low bits.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  // Doubleword indexes decoded by the header.
  localparam int DW_IDENT = 0;
  localparam int DW_CMDST = 1;
  localparam int DW_CLASS = 2;
  localparam int DW_MISC  = 3;
  localparam int DW_BASE  = 4;

  typedef struct packed {
    logic parity;
    logic mabort;
    logic tabort_rcv;
    logic tabort_sig;
  } bus_evt_t;

  // Byte-lane write merge: only bits both enabled by a lane and writable move.
  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [LANES-1:0]  be,
    input logic [WORD_W-1:0] wmask
  );
    logic [WORD_W-1:0] lm;
    for (int i = 0; i < LANES; i++) lm[8*i +: 8] = be[i] ? 8'hFF : 8'h00;
    return (old_w & ~(lm & wmask)) | (new_w & lm & wmask);
  endfunction

endpackage

// File: rtl/cfg_cmd_stat.sv
module cfg_cmd_stat
  import cfg_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  input  bus_evt_t          evt,
  output logic [15:0]       cmd_o,
  output logic [15:0]       stat_o
);

  localparam logic [WORD_W-1:0] CMD_WMASK = 32'h0000_0006;

  logic [WORD_W-1:0] cmd_q;
  bus_evt_t          sticky_q;
  bus_evt_t          clr;

  // Write-one-to-clear, only through the top byte lane.
  always_comb begin
    clr = '0;
    if (wr_sel && be[LANES-1]) begin
      clr.parity     = wdata[31];
      clr.mabort     = wdata[29];
      clr.tabort_rcv = wdata[28];
      clr.tabort_sig = wdata[27];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      sticky_q <= '0;
    end else begin
      if (wr_sel) cmd_q <= lane_merge(cmd_q, wdata, be, CMD_WMASK);
      // An event outranks a simultaneous clear.
      sticky_q <= (sticky_q & ~clr) | evt;
    end
  end

  assign cmd_o  = cmd_q[15:0] | cmd_q[31:16];
  assign stat_o = {sticky_q.parity, 1'b0, sticky_q.mabort, sticky_q.tabort_rcv,
                   sticky_q.tabort_sig, 2'b00, 1'b0, 1'b0, 7'b0};

endmodule

// File: rtl/cfg_bar_lat.sv
module cfg_bar_lat
  import cfg_hdr_pkg::*;
#(
  parameter int WIN_BITS = 12,
  parameter int LAT_RO   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_misc,
  input  logic              wr_base,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  input  logic              mem_en,
  input  logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] misc_o,
  output logic [WORD_W-1:0] base_o,
  output logic              hit_o
);

  localparam logic [WORD_W-1:0] LAT_FIXED  = WORD_W'((64'd1 << LAT_RO) - 1) << 8;
  localparam logic [WORD_W-1:0] MISC_WMASK = 32'h0000_FF00 & ~LAT_FIXED;
  localparam logic [WORD_W-1:0] BASE_WMASK = ~WORD_W'((64'd1 << WIN_BITS) - 1);

  logic [WORD_W-1:0] misc_q;
  logic [WORD_W-1:0] base_q;
  logic              hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      misc_q <= '0;
      base_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      if (wr_misc) misc_q <= lane_merge(misc_q, wdata, be, MISC_WMASK);
      if (wr_base) base_q <= lane_merge(base_q, wdata, be, BASE_WMASK);
      hit_q <= mem_en && ((mem_addr & BASE_WMASK) == base_q);
    end
  end

  assign misc_o = misc_q;
  assign base_o = base_q;
  assign hit_o  = hit_q;

endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_hdr_pkg::*;
#(
  parameter int DW_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [DW_W-1:0]   dw,
  input  logic [WORD_W-1:0] ident_w,
  input  logic [WORD_W-1:0] cmdst_w,
  input  logic [WORD_W-1:0] class_w,
  input  logic [WORD_W-1:0] misc_w,
  input  logic [WORD_W-1:0] base_w,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  logic [WORD_W-1:0] sel_w;

  always_comb begin
    case (int'(dw))
      DW_IDENT: sel_w = ident_w;
      DW_CMDST: sel_w = cmdst_w;
      DW_CLASS: sel_w = class_w;
      DW_MISC:  sel_w = misc_w;
      DW_BASE:  sel_w = base_w;
      default:  sel_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= sel_w;
    end
  end

endmodule

// File: rtl/cfg_space_hdr.sv
module cfg_space_hdr
  import cfg_hdr_pkg::*;
#(
  parameter int          CFG_BYTES  = 256,
  parameter logic [15:0] DEV_ID     = 16'h6057,
  parameter logic [15:0] VEN_ID     = 16'h11DE,
  parameter logic [23:0] CLASS_CODE = 24'h040000,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter int          WIN_BITS   = 12,
  parameter int          LAT_RO     = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_req,
  input  logic                           cfg_wr,
  input  logic [$clog2(CFG_BYTES/4)-1:0] cfg_dw,
  input  logic [3:0]                     cfg_be,
  input  logic [31:0]                    cfg_wdata,
  output logic [31:0]                    cfg_rdata,
  output logic                           cfg_rvalid,
  input  logic                           ev_parity,
  input  logic                           ev_mabort,
  input  logic                           ev_tabort_rcv,
  input  logic                           ev_tabort_sig,
  input  logic [31:0]                    mem_addr,
  output logic                           mem_hit,
  output logic                           mem_space_en,
  output logic                           bus_master_en,
  output logic [7:0]                     lat_timer
);

  localparam int DW_W = $clog2(CFG_BYTES / 4);

  logic              wr_cmdst, wr_misc, wr_base, rd_req;
  logic [15:0]       cmd_w, stat_w;
  logic [WORD_W-1:0] misc_w, base_w;
  bus_evt_t          evt;

  assign wr_cmdst = cfg_req && cfg_wr && (int'(cfg_dw) == DW_CMDST);
  assign wr_misc  = cfg_req && cfg_wr && (int'(cfg_dw) == DW_MISC);
  assign wr_base  = cfg_req && cfg_wr && (int'(cfg_dw) == DW_BASE);
  assign rd_req   = cfg_req && !cfg_wr;

  assign evt = '{parity: ev_parity, mabort: ev_mabort,
                 tabort_rcv: ev_tabort_rcv, tabort_sig: ev_tabort_sig};

  cfg_cmd_stat u_cmd (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (wr_cmdst),
    .be     (cfg_be),
    .wdata  (cfg_wdata),
    .evt    (evt),
    .cmd_o  (cmd_w),
    .stat_o (stat_w)
  );

  cfg_bar_lat #(.WIN_BITS(WIN_BITS), .LAT_RO(LAT_RO)) u_bar (
    .clk      (clk),
    .rst      (rst),
    .wr_misc  (wr_misc),
    .wr_base  (wr_base),
    .be       (cfg_be),
    .wdata    (cfg_wdata),
    .mem_en   (cmd_w[1]),
    .mem_addr (mem_addr),
    .misc_o   (misc_w),
    .base_o   (base_w),
    .hit_o    (mem_hit)
  );

  cfg_rd_mux #(.DW_W(DW_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .dw      (cfg_dw),
    .ident_w ({DEV_ID, VEN_ID}),
    .cmdst_w ({stat_w, cmd_w}),
    .class_w ({CLASS_CODE, REV_ID}),
    .misc_w  (misc_w),
    .base_w  (base_w),
    .rdata   (cfg_rdata),
    .rvalid  (cfg_rvalid)
  );

  assign mem_space_en  = cmd_w[1];
  assign bus_master_en = cmd_w[2];
  assign lat_timer     = misc_w[15:8];

endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk #(
  parameter int          DW_W    = 6,
  parameter logic [31:0] ID_WORD = 32'h605711DE
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_req,
  input logic            cfg_wr,
  input logic [DW_W-1:0] cfg_dw,
  input logic [3:0]      cfg_be,
  input logic [31:0]     cfg_wdata,
  input logic [31:0]     cfg_rdata,
  input logic            cfg_rvalid,
  input logic            ev_parity,
  input logic            mem_hit,
  input logic            mem_space_en,
  input logic            bus_master_en,
  input logic [15:0]     status
);

  logic rd_now, par_clr;
  assign rd_now  = cfg_req && !cfg_wr;
  assign par_clr = cfg_req && cfg_wr && (cfg_dw == DW_W'(1)) && cfg_be[3] && cfg_wdata[31];

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!mem_hit && !cfg_rvalid && !mem_space_en && !bus_master_en && status == 16'h0));

  a_r2_ident_read: assert property (@(posedge clk) disable iff (rst)
    (rd_now && cfg_dw == '0) |=> (cfg_rdata == ID_WORD));

  a_r7_parity_sets: assert property (@(posedge clk) disable iff (rst)
    ev_parity |=> status[15]);

  a_r8_parity_sticks: assert property (@(posedge clk) disable iff (rst)
    (status[15] && !par_clr) |=> status[15]);

  a_r11_hit_gated: assert property (@(posedge clk) disable iff (rst)
    mem_hit |-> $past(mem_space_en));

  a_r12_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    rd_now |=> cfg_rvalid);

  a_r12_no_stray_rvalid: assert property (@(posedge clk) disable iff (rst)
    !rd_now |=> !cfg_rvalid);

endmodule

bind cfg_space_hdr cfg_hdr_chk #(.DW_W(DW_W), .ID_WORD({DEV_ID, VEN_ID})) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_req       (cfg_req),
  .cfg_wr        (cfg_wr),
  .cfg_dw        (cfg_dw),
  .cfg_be        (cfg_be),
  .cfg_wdata     (cfg_wdata),
  .cfg_rdata     (cfg_rdata),
  .cfg_rvalid    (cfg_rvalid),
  .ev_parity     (ev_parity),
  .mem_hit       (mem_hit),
  .mem_space_en  (mem_space_en),
  .bus_master_en (bus_master_en),
  .status        (stat_w)
);

// File: tb/sim_cfg_space_hdr.sv
`timescale 1ns/1ps
module sim_cfg_space_hdr;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_req = 1'b0, cfg_wr = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        ev_parity = 0, ev_mabort = 0, ev_tabort_rcv = 0, ev_tabort_sig = 0;
  logic [31:0] mem_addr = '0;
  logic        mem_hit, mem_space_en, bus_master_en;
  logic [7:0]  lat_timer;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cfg_space_hdr u0 (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .ev_parity(ev_parity), .ev_mabort(ev_mabort), .ev_tabort_rcv(ev_tabort_rcv),
    .ev_tabort_sig(ev_tabort_sig), .mem_addr(mem_addr), .mem_hit(mem_hit),
    .mem_space_en(mem_space_en), .bus_master_en(bus_master_en), .lat_timer(lat_timer)
  );

  // Row: {wr, dw, be, wdata, expected read word}
  localparam int NV = 23;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 6'd0,  4'hF, 32'h0,        32'h605711DE}, // R2
    {1'b1, 6'd0,  4'hF, 32'hFFFFFFFF, 32'h0},        // R2 write ignored
    {1'b0, 6'd0,  4'hF, 32'h0,        32'h605711DE}, // R2
    {1'b0, 6'd2,  4'hF, 32'h0,        32'h04000001}, // R3
    {1'b1, 6'd1,  4'hF, 32'h0000FFFF, 32'h0},        // R5 set command bits
    {1'b0, 6'd1,  4'hF, 32'h0,        32'h00000006}, // R5 R6
    {1'b1, 6'd1,  4'h0, 32'h0,        32'h0},        // R5 no lanes
    {1'b0, 6'd1,  4'hF, 32'h0,        32'h00000006}, // R5
    {1'b1, 6'd1,  4'h1, 32'h0,        32'h0},        // R5 clear via lane 0
    {1'b0, 6'd1,  4'hF, 32'h0,        32'h00000000}, // R5
    {1'b1, 6'd3,  4'hF, 32'hFFFFFFFF, 32'h0},        // R9
    {1'b0, 6'd3,  4'hF, 32'h0,        32'h0000F800}, // R9
    {1'b1, 6'd4,  4'hF, 32'hFFFFFFFF, 32'h0},        // R10
    {1'b0, 6'd4,  4'hF, 32'h0,        32'hFFFFF000}, // R10
    {1'b1, 6'd4,  4'h8, 32'h12345678, 32'h0},        // R10 lane 3 only
    {1'b0, 6'd4,  4'hF, 32'h0,        32'h12FFF000}, // R10
    {1'b1, 6'd5,  4'hF, 32'hFFFFFFFF, 32'h0},        // R4
    {1'b0, 6'd5,  4'hF, 32'h0,        32'h00000000}, // R4
    {1'b0, 6'd63, 4'hF, 32'h0,        32'h00000000}, // R4 last index
    {1'b1, 6'd3,  4'hD, 32'h0,        32'h0},        // R9 lane 1 off
    {1'b0, 6'd3,  4'hF, 32'h0,        32'h0000F800}, // R9
    {1'b1, 6'd4,  4'h2, 32'h0000AB00, 32'h0},        // R10 lane 1 only
    {1'b0, 6'd4,  4'hF, 32'h0,        32'h12FFA000}  // R10
  };
  localparam string VTAG [NV] = '{"R2","R2","R2","R3","R5","R6","R5","R5","R5","R5",
    "R9","R9","R10","R10","R10","R10","R4","R4","R4","R9","R9","R10","R10"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [5:0] dw, input logic [3:0] be,
                        input logic [31:0] d, input logic chk, input logic [31:0] exp,
                        input string tag);
    @(negedge clk);
    cfg_req = 1'b1; cfg_wr = wr; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 1'b0; cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
    if (wr) check({tag, " rvalid after write R12"}, {31'b0, cfg_rvalid}, 32'h0);
    else begin
      check({tag, " rvalid R12"}, {31'b0, cfg_rvalid}, 32'h1);
      if (chk) check(tag, cfg_rdata, exp);
    end
  endtask

  task automatic rd(input logic [5:0] dw, input logic [31:0] exp, input string tag);
    access(1'b0, dw, 4'hF, 32'h0, 1'b1, exp, tag);
  endtask

  task automatic wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    access(1'b1, dw, be, d, 1'b0, 32'h0, "write");
  endtask

  task automatic hit_at(input logic [31:0] a, input logic exp, input string tag);
    @(negedge clk); mem_addr = a;
    @(negedge clk);
    check(tag, {31'b0, mem_hit}, {31'b0, exp});
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state at the ports
    check("R1 rdata", cfg_rdata, 32'h0);
    check("R1 rvalid", {31'b0, cfg_rvalid}, 32'h0);
    check("R1 hit", {31'b0, mem_hit}, 32'h0);
    check("R1 enables", {30'b0, bus_master_en, mem_space_en}, 32'h0);
    check("R1 lat", {24'b0, lat_timer}, 32'h0);
    rd(6'd1, 32'h0, "R1 cmd/status");
    rd(6'd4, 32'h0, "R1 base");

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][74], VEC[i][73:68], VEC[i][67:64], VEC[i][63:32], 1'b1,
             VEC[i][31:0], VTAG[i]);
    end
    check("R9 lat port", {24'b0, lat_timer}, 32'h000000F8);

    // R7 events set sticky flags with command bits zero
    @(negedge clk); ev_parity = 1; ev_mabort = 1;
    @(negedge clk); ev_parity = 0; ev_mabort = 0;
    rd(6'd1, 32'hA0000000, "R7 parity+mabort");
    @(negedge clk); ev_tabort_rcv = 1;
    @(negedge clk); ev_tabort_rcv = 0;
    rd(6'd1, 32'hB0000000, "R7 tabort_rcv");

    // R8 write-one-to-clear, lane gating, write zero, event priority
    wr(6'd1, 4'h8, 32'h80000000);
    rd(6'd1, 32'h30000000, "R8 clear parity");
    wr(6'd1, 4'h7, 32'hFFFFFFFF);
    rd(6'd1, 32'h30000006, "R8 lane3 off / R5");
    wr(6'd1, 4'h8, 32'h00000000);
    rd(6'd1, 32'h30000006, "R8 write zero");
    @(negedge clk);
    ev_tabort_sig = 1; cfg_req = 1; cfg_wr = 1; cfg_dw = 6'd1; cfg_be = 4'h8;
    cfg_wdata = 32'h08000000;
    @(negedge clk);
    ev_tabort_sig = 0; cfg_req = 0; cfg_wr = 0; cfg_be = '0; cfg_wdata = '0;
    rd(6'd1, 32'h38000006, "R8 event beats clear");
    wr(6'd1, 4'h8, 32'h78000000);
    rd(6'd1, 32'h00000006, "R8 clear all R6");

    // R11 window hit
    hit_at(32'h12FFA123, 1'b1, "R11 inside");
    hit_at(32'h12FFA000, 1'b1, "R11 low edge");
    hit_at(32'h12FFAFFF, 1'b1, "R11 high edge");
    hit_at(32'h12FFB000, 1'b0, "R11 next page");
    hit_at(32'h02FFA000, 1'b0, "R11 top byte differs");
    wr(6'd1, 4'h1, 32'h00000004);
    check("R5 master port", {30'b0, bus_master_en, mem_space_en}, 32'h2);
    hit_at(32'h12FFA000, 1'b0, "R11 disabled");

    // R1 reset again after activity
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 hit after reset", {31'b0, mem_hit}, 32'h0);
    rd(6'd1, 32'h0, "R1 status after reset");
    rd(6'd3, 32'h0, "R1 lat after reset");
    rd(6'd4, 32'h0, "R1 base after reset");

    finish_run();
  end

endmodule